// File: doc/BRIEF.md
# Upstream Link Picker with Timeout Fault Masking

This block forms the receive side of one node in a linear chain of processing nodes. Three handshake links come in from the nodes one, two and three positions upstream. Each link has an 8-bit data bus, a stage tag, a request line driven by the sender and an acknowledge line driven back by this block. The block polls one link at a time, starting with the nearest. It takes the first request it finds and hands the data word and the stage tag to the local compute logic. The stage tag names the last stage already executed upstream.

No separate diagnosis logic is needed. A link whose request stays low for the whole of its retry budget is declared faulty and masked until reset, and polling moves to the next farther link. Each link has its own budget, counted in wait periods, so a farther link can be given more time than a nearer one. If all three links time out, the node cannot be fed. The block then raises a sticky failure flag and stops acknowledging.

Top module: `upstream_link_picker`

## Requirements
- R1: After reset all acknowledges, `rx_valid` and `system_fail` are low and polling starts on link 0 (distance 1, bits [7:0] of `up_data` and [3:0] of `up_stage`); link k uses bits [8k+7:8k] and [4k+3:4k].
- R2: When the polled link's request is high at a clock edge, that link's acknowledge rises at that edge. At the same edge its data and stage tag are latched onto `rx_data`/`rx_stage`, and `rx_valid` is high for exactly that one cycle.
- R3: At most one acknowledge is high at any time. An acknowledge stays high while its request stays high and falls at the first edge that sees the request low (four-phase handshake). The captured values stay unchanged meanwhile.
- R4: While a link is polled, a wait period is WAIT_LEN cycles. After RETRY_LIMITS budget many silent wait periods, the link is masked and polling moves to the next farther healthy link. With the defaults (WAIT_LEN 4, budget 3 for link 0) a request seen at the 12th silent edge is still taken, and otherwise link 0 is dropped at that edge.
- R5: Budgets are per link: by default link 1 gets 4 wait periods (16 cycles) and link 2 gets 5 (20 cycles), each counted from the edge at which polling reached it.
- R6: A masked link stays masked until reset and its request is never acknowledged. After each completed transfer, polling restarts at the nearest unmasked link.
- R7: When the last unmasked link times out, `system_fail` rises at that edge and stays high until reset, and no acknowledge is raised afterwards.
- R8: A request on a link that is not being polled is ignored until polling reaches that link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 3 | Request from upstream nodes, bit k = distance k+1 |
| up_data | input | 24 | Data buses of the three links, 8 bits each |
| up_stage | input | 12 | Stage tags of the three links, 4 bits each |
| up_ack | output | 3 | Acknowledge back to each upstream node |
| rx_data | output | 8 | Captured data word |
| rx_stage | output | 4 | Captured stage tag |
| rx_valid | output | 1 | One-cycle pulse on capture |
| system_fail | output | 1 | Sticky flag: every upstream link timed out |

## Verification
The block is driven with a prompt request on the nearest link and with two back-to-back transfers that carry different data. These show that capture, the valid pulse and the handshake release work. A request raised on the last cycle of link 0's budget, compared against a request on link 1 held from reset, pins the exact timeout edge and shows that a non-polled request is ignored. A request on link 2 held from reset separates the per-link budgets. Total silence followed by requests on every link shows the failure flag, that it is sticky, and that masked links are never acknowledged.

// File: rtl/ulp_pkg.sv
package ulp_pkg;

   typedef enum logic [1:0] {
      ST_POLL = 2'd0,
      ST_HOLD = 2'd1,
      ST_DEAD = 2'd2
   } rx_state_e;

endpackage

// File: rtl/ulp_poll_timer.sv
// Wait-period and retry counter for the link currently being polled.
module ulp_poll_timer #(
   parameter int unsigned WAIT_LEN = 4,
   parameter int unsigned LIM_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [LIM_W-1:0] limit,
   output logic             expire
);

   logic             period_hit;
   logic [LIM_W-1:0] miss_q;

   generate
      if (WAIT_LEN == 1) begin : g_unit_period
         assign period_hit = run;
      end else begin : g_long_period
         localparam int unsigned PER_W = $clog2(WAIT_LEN);
         logic [PER_W-1:0] period_q;
         assign period_hit = run && (period_q == PER_W'(WAIT_LEN - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               period_q <= '0;
            end else if (run) begin
               period_q <= period_hit ? '0 : period_q + 1'b1;
            end
         end
      end
   endgenerate

   assign expire = period_hit && (miss_q == limit - LIM_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         miss_q <= '0;
      end else if (period_hit) begin
         miss_q <= miss_q + 1'b1;
      end
   end

   // R4: the miss count never passes the budget of the polled link
   p_miss_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (miss_q < limit));

endmodule

// File: rtl/ulp_link_mux.sv
// Picks request, data and stage tag of the polled link.
module ulp_link_mux #(
   parameter int unsigned NUM_LINKS = 3,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned STAGE_W   = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic [IDX_W-1:0]           sel,
   input  logic [NUM_LINKS-1:0]       mask,
   input  logic [NUM_LINKS-1:0]       up_req,
   input  logic [NUM_LINKS*DATA_W-1:0]  up_data,
   input  logic [NUM_LINKS*STAGE_W-1:0] up_stage,
   output logic                       req_sel,
   output logic [DATA_W-1:0]          data_sel,
   output logic [STAGE_W-1:0]         stage_sel
);

   logic [DATA_W-1:0]  data_arr  [NUM_LINKS];
   logic [STAGE_W-1:0] stage_arr [NUM_LINKS];
   logic [NUM_LINKS-1:0] live;

   generate
      for (genvar k = 0; k < NUM_LINKS; k++) begin : g_slice
         assign data_arr[k]  = up_data[k*DATA_W +: DATA_W];
         assign stage_arr[k] = up_stage[k*STAGE_W +: STAGE_W];
         assign live[k]      = up_req[k] & ~mask[k];
      end
   endgenerate

   always_comb begin
      req_sel   = 1'b0;
      data_sel  = '0;
      stage_sel = '0;
      for (int k = 0; k < NUM_LINKS; k++) begin
         if (sel == IDX_W'(k)) begin
            req_sel   = live[k];
            data_sel  = data_arr[k];
            stage_sel = stage_arr[k];
         end
      end
   end

endmodule

// File: rtl/ulp_fault_mask.sv
// Sticky per-link fault bits and nearest-healthy-link search.
module ulp_fault_mask #(
   parameter int unsigned NUM_LINKS = 3,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mark,
   input  logic [IDX_W-1:0]     mark_idx,
   output logic [NUM_LINKS-1:0] mask,
   output logic [IDX_W-1:0]     first_now,
   output logic [IDX_W-1:0]     first_after,
   output logic                 any_after
);

   logic [NUM_LINKS-1:0] mask_q;
   logic [NUM_LINKS-1:0] mask_next;

   assign mask      = mask_q;
   assign mask_next = mask_q | (NUM_LINKS'(1) << mark_idx);

   always_comb begin
      first_now   = '0;
      first_after = '0;
      for (int k = NUM_LINKS - 1; k >= 0; k--) begin
         if (!mask_q[k])    first_now   = IDX_W'(k);
         if (!mask_next[k]) first_after = IDX_W'(k);
      end
      any_after = ~&mask_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (mark) begin
         mask_q <= mask_next;
      end
   end

   generate
      for (genvar k = 0; k < NUM_LINKS; k++) begin : g_chk
         // R6: a fault bit, once set, holds until reset
         p_mask_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[k] |=> mask_q[k]);
      end
   endgenerate

endmodule

// File: rtl/upstream_link_picker.sv
module upstream_link_picker #(
   parameter int unsigned NUM_LINKS    = 3,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned STAGE_W      = 4,
   parameter int unsigned WAIT_LEN     = 4,
   parameter int unsigned LIM_W        = 8,
   parameter logic [NUM_LINKS*LIM_W-1:0] RETRY_LIMITS = {8'd5, 8'd4, 8'd3}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LINKS-1:0]          up_req,
   input  logic [NUM_LINKS*DATA_W-1:0]   up_data,
   input  logic [NUM_LINKS*STAGE_W-1:0]  up_stage,
   output logic [NUM_LINKS-1:0]          up_ack,
   output logic [DATA_W-1:0]             rx_data,
   output logic [STAGE_W-1:0]            rx_stage,
   output logic                          rx_valid,
   output logic                          system_fail
);
   import ulp_pkg::*;

   localparam int unsigned IDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

   // elaboration checks
   generate
      if (NUM_LINKS < 1) begin : g_bad_links
         $error("NUM_LINKS must be at least 1");
      end
      if (DATA_W < 1 || STAGE_W < 1) begin : g_bad_width
         $error("DATA_W and STAGE_W must be at least 1");
      end
      if (WAIT_LEN < 1) begin : g_bad_wait
         $error("WAIT_LEN must be at least 1");
      end
      for (genvar k = 0; k < NUM_LINKS; k++) begin : g_lim_chk
         if (RETRY_LIMITS[k*LIM_W +: LIM_W] == 0) begin : g_zero
            $error("every retry budget must be non-zero");
         end
      end
   endgenerate

   rx_state_e            state_q;
   logic [IDX_W-1:0]     cur_q;
   logic [NUM_LINKS-1:0] ack_q;
   logic [DATA_W-1:0]    data_q;
   logic [STAGE_W-1:0]   stage_q;
   logic                 valid_q;
   logic                 fail_q;

   logic                 req_sel;
   logic [DATA_W-1:0]    data_sel;
   logic [STAGE_W-1:0]   stage_sel;
   logic [NUM_LINKS-1:0] fault_mask;
   logic [IDX_W-1:0]     first_now;
   logic [IDX_W-1:0]     first_after;
   logic                 any_after;
   logic                 run;
   logic                 expire;
   logic [LIM_W-1:0]     cur_limit;

   assign run       = (state_q == ST_POLL) && !req_sel;
   assign cur_limit = RETRY_LIMITS[cur_q*LIM_W +: LIM_W];

   ulp_link_mux #(
      .NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .STAGE_W(STAGE_W), .IDX_W(IDX_W)
   ) u_mux (
      .sel      (cur_q),
      .mask     (fault_mask),
      .up_req   (up_req),
      .up_data  (up_data),
      .up_stage (up_stage),
      .req_sel  (req_sel),
      .data_sel (data_sel),
      .stage_sel(stage_sel)
   );

   ulp_poll_timer #(
      .WAIT_LEN(WAIT_LEN), .LIM_W(LIM_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!run || expire),
      .run   (run),
      .limit (cur_limit),
      .expire(expire)
   );

   ulp_fault_mask #(
      .NUM_LINKS(NUM_LINKS), .IDX_W(IDX_W)
   ) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .mark       (expire),
      .mark_idx   (cur_q),
      .mask       (fault_mask),
      .first_now  (first_now),
      .first_after(first_after),
      .any_after  (any_after)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_POLL;
         cur_q   <= '0;
         ack_q   <= '0;
         data_q  <= '0;
         stage_q <= '0;
         valid_q <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state_q)
            ST_POLL: begin
               if (req_sel) begin
                  ack_q   <= NUM_LINKS'(1) << cur_q;
                  data_q  <= data_sel;
                  stage_q <= stage_sel;
                  valid_q <= 1'b1;
                  state_q <= ST_HOLD;
               end else if (expire) begin
                  if (any_after) begin
                     cur_q <= first_after;
                  end else begin
                     fail_q  <= 1'b1;
                     state_q <= ST_DEAD;
                  end
               end
            end
            ST_HOLD: begin
               if (!req_sel) begin
                  ack_q   <= '0;
                  cur_q   <= first_now;
                  state_q <= ST_POLL;
               end
            end
            default: begin
               ack_q <= '0;
            end
         endcase
      end
   end

   assign up_ack      = ack_q;
   assign rx_data     = data_q;
   assign rx_stage    = stage_q;
   assign rx_valid    = valid_q;
   assign system_fail = fail_q;

   // R3: never more than one acknowledge
   p_one_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(up_ack));

   generate
      for (genvar k = 0; k < NUM_LINKS; k++) begin : g_hs_chk
         // R3: acknowledge held while request held
         p_ack_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (up_ack[k] && up_req[k]) |=> up_ack[k]);
         // R3: acknowledge released once request drops
         p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (up_ack[k] && !up_req[k]) |=> !up_ack[k]);
      end
   endgenerate

   // R2: valid is a single-cycle pulse
   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R2: valid comes with exactly one acknowledge
   p_valid_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($countones(up_ack) == 1));

   // R3: captured values hold during the handshake
   p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((up_ack != '0) && !rx_valid) |-> ($stable(rx_data) && $stable(rx_stage)));

   // R6: masked links are never acknowledged
   p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mask & up_ack) == '0);

   // R7: failure flag is sticky
   p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      system_fail |=> system_fail);

   // R7: a failed node acknowledges nothing
   p_fail_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      system_fail |-> (up_ack == '0));

endmodule

// File: tb/test_upstream_link_picker.sv
`timescale 1ns/1ps
module test_upstream_link_picker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  up_req = '0;
   logic [23:0] up_data = '0;
   logic [11:0] up_stage = '0;
   logic [2:0]  up_ack;
   logic [7:0]  rx_data;
   logic [3:0]  rx_stage;
   logic        rx_valid;
   logic        system_fail;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   upstream_link_picker i_upstream_link_picker (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_req     (up_req),
      .up_data    (up_data),
      .up_stage   (up_stage),
      .up_ack     (up_ack),
      .rx_data    (rx_data),
      .rx_stage   (rx_stage),
      .rx_valid   (rx_valid),
      .system_fail(system_fail)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(int k, bit r, logic [7:0] d, logic [3:0] s);
      up_req[k]            = r;
      up_data[k*8 +: 8]    = d;
      up_stage[k*4 +: 4]   = s;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      up_req   = '0;
      up_data  = '0;
      up_stage = '0;
      edges(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", "ack", up_ack, 3'b000);
      check("R1", "valid", rx_valid, 1'b0);
      check("R1", "fail", system_fail, 1'b0);
   endtask

   task automatic t_basic();
      do_reset();
      drive(0, 1'b1, 8'hA5, 4'd3);
      edges(1);
      check("R2", "ack after req", up_ack, 3'b001);
      check("R2", "valid pulse", rx_valid, 1'b1);
      check("R2", "data", rx_data, 8'hA5);
      check("R2", "stage", rx_stage, 4'd3);
      drive(0, 1'b1, 8'h11, 4'd9);
      edges(1);
      check("R2", "valid one cycle", rx_valid, 1'b0);
      check("R3", "ack held", up_ack, 3'b001);
      check("R3", "data held", rx_data, 8'hA5);
      drive(0, 1'b0, 8'h00, 4'd0);
      edges(1);
      check("R3", "ack released", up_ack, 3'b000);
      drive(0, 1'b1, 8'h3C, 4'd5);
      edges(1);
      check("R3", "second ack", up_ack, 3'b001);
      check("R2", "second data", rx_data, 8'h3C);
      check("R2", "second stage", rx_stage, 4'd5);
      drive(0, 1'b0, 8'h00, 4'd0);
      edges(1);
   endtask

   task automatic t_last_chance();
      do_reset();
      edges(11);
      drive(0, 1'b1, 8'h77, 4'd1);
      edges(1);
      check("R4", "req at 12th edge taken", up_ack, 3'b001);
      check("R4", "data", rx_data, 8'h77);
   endtask

   task automatic t_fallback();
      do_reset();
      drive(1, 1'b1, 8'h5A, 4'd7);
      edges(12);
      check("R8", "link1 ignored while link0 polled", up_ack, 3'b000);
      edges(1);
      check("R4", "link1 taken after link0 timeout", up_ack, 3'b010);
      check("R4", "data", rx_data, 8'h5A);
      check("R4", "stage", rx_stage, 4'd7);
      drive(1, 1'b0, 8'h00, 4'd0);
      edges(1);
      check("R3", "link1 released", up_ack, 3'b000);
      drive(0, 1'b1, 8'hEE, 4'd2);
      edges(5);
      check("R6", "masked link0 ignored", up_ack, 3'b000);
      drive(1, 1'b1, 8'h42, 4'd8);
      edges(1);
      check("R6", "restart at nearest healthy", up_ack, 3'b010);
      check("R6", "data", rx_data, 8'h42);
      drive(1, 1'b0, 8'h00, 4'd0);
      drive(0, 1'b0, 8'h00, 4'd0);
      edges(1);
   endtask

   task automatic t_far_budget();
      do_reset();
      drive(2, 1'b1, 8'hC3, 4'd4);
      edges(28);
      check("R5", "link2 not yet polled", up_ack, 3'b000);
      edges(1);
      check("R5", "link2 taken at edge 29", up_ack, 3'b100);
      check("R5", "data", rx_data, 8'hC3);
      drive(2, 1'b0, 8'h00, 4'd0);
      edges(1);
   endtask

   task automatic t_all_dead();
      do_reset();
      edges(47);
      check("R7", "fail before last timeout", system_fail, 1'b0);
      edges(1);
      check("R7", "fail at last timeout", system_fail, 1'b1);
      drive(0, 1'b1, 8'h01, 4'd1);
      drive(1, 1'b1, 8'h02, 4'd2);
      drive(2, 1'b1, 8'h03, 4'd3);
      edges(5);
      check("R7", "no ack after fail", up_ack, 3'b000);
      check("R7", "fail sticky", system_fail, 1'b1);
      check("R7", "no valid after fail", rx_valid, 1'b0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_last_chance();
      t_fallback();
      t_far_budget();
      t_all_dead();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule